// File: doc/BRIEF.md
# UART Baud Clock Generator

This block derives the oversampling enable for a UART's transmit and receive paths from a single fast reference clock. The reference first passes a two-way prescaler. The prescaler either passes every reference cycle or only every fourth one. A 16-bit programmable divisor then counts the prescaled enables. Each completed count gives a one-cycle `tick16` pulse at sixteen times the serial bit rate. Every sixteenth such pulse is also flagged on `tick1` as a bit-rate strobe.

A host sets the block up through a small byte-wide write port. The divisor is split into a low byte and a high byte. The low byte is held aside until the high byte is written, so the counter never sees half of an update. A control register selects the prescaler. New settings never cut a period short. The counter finishes its current period with the old values and picks up the new ones at its terminal count. A zero divisor parks the generator, and it starts on its own once a nonzero value is committed. All outputs are enables in the reference clock domain, not derived clocks.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the committed divisor is zero. `tick16` and `tick1` stay low until a high-byte write commits a nonzero divisor.
- R2: A write to address 0 (divisor low byte) is held aside and changes nothing on its own. A write to address 1 (high byte) commits the divisor {high byte, held low byte}.
- R3: A write to address 2 sets the prescaler from data bit 7: 0 selects divide-by-1 and 1 selects divide-by-4. The other data bits have no effect.
- R4: With settings unchanged, `tick16` is a one-cycle pulse repeating every P×D reference cycles. P is 1 or 4 and D is any divisor from 1 to 65535.
- R5: New divisor or prescaler settings take effect only at the next `tick16`. The period in progress completes with the old settings, so no shortened period appears.
- R6: Committing a divisor of 0 while running lets the current period finish with one last `tick16`. No further pulses follow.
- R7: `tick1` is high exactly in the cycle of every sixteenth `tick16`, so 16 `tick16` pulses fall between consecutive `tick1` pulses.
- R8: A write to address 3 changes no setting.
- R9: Divisor 1 with divide-by-1 yields `tick16` in every reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 unused |
| wr_data | input | 8 | Write data |
| tick16 | output | 1 | One-cycle 16x oversampling enable |
| tick1 | output | 1 | One-cycle bit-rate enable, coincident with every 16th tick16 |

## Verification
Intervals between `tick16` pulses are measured for fixed directed settings. These include the fastest setting (divide-by-1, divisor 1) and a divisor with both bytes nonzero, which tells a correctly assembled 16-bit value from one that drops a byte. Changes are written just after a pulse, so the next interval shows whether the old settings were kept for the period in progress and the one after shows the new ones. A switch from divide-by-1 to divide-by-4 is kept apart from a write that sets only the other control bits. Stray low-byte-only and unused-address writes must leave the interval unchanged. A run of seeded random divisor and prescaler pairs then compares each settled interval with P×D.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIV_LO = 2'd0,
    REG_DIV_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // Reference cycles per prescaled enable.
  function automatic int unsigned prescale_ratio(input logic slow, input int unsigned slow_ratio);
    return slow ? slow_ratio : 1;
  endfunction

  // Reference cycles between 16x ticks for given settings.
  function automatic int unsigned tick_period(input logic slow, input int unsigned slow_ratio,
                                              input int unsigned divisor);
    return prescale_ratio(slow, slow_ratio) * divisor;
  endfunction
endpackage

// File: rtl/baud_regs.sv
`timescale 1ns/1ps
module baud_regs
  import baud_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned SEL_BIT = 7,
  localparam int unsigned DIV_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  staged_div,
  output logic              staged_slow
);
  logic [BYTE_W-1:0] lo_hold;
  logic wr_lo, wr_hi, wr_ctrl, wr_spare;

  assign wr_lo    = wr_en && (wr_addr == REG_DIV_LO);
  assign wr_hi    = wr_en && (wr_addr == REG_DIV_HI);
  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_spare = wr_en && (wr_addr == REG_SPARE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold     <= '0;
      staged_div  <= '0;
      staged_slow <= 1'b0;
    end else begin
      if (wr_lo)   lo_hold     <= wr_data;
      if (wr_hi)   staged_div  <= {wr_data, lo_hold};
      if (wr_ctrl) staged_slow <= wr_data[SEL_BIT];
    end
  end

  // R2: a low-byte write alone leaves the committed divisor untouched
  a_r2_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> $stable(staged_div));

  // R8: the unused address changes no setting
  a_r8_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spare |=> ($stable(staged_div) && $stable(staged_slow)));
endmodule

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler #(
  parameter int unsigned PRE_SLOW = 4,
  localparam int unsigned PCNT_W  = $clog2(PRE_SLOW)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic slow,
  output logic pre_en
);
  localparam logic [PCNT_W-1:0] SLOW_LAST = PCNT_W'(PRE_SLOW - 1);

  logic [PCNT_W-1:0] pcnt;

  assign pre_en = run && (slow ? (pcnt == SLOW_LAST) : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                       pcnt <= '0;
    else if (!run || restart || pre_en) pcnt <= '0;
    else                              pcnt <= pcnt + 1'b1;
  end

  // R1/R4: prescaler phase is cleared while parked so the first period is whole
  a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0));

  // R3: in divide-by-1 mode the phase counter never advances
  a_r3_fast_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slow) |=> (pcnt == '0));
endmodule

// File: rtl/baud_divider.sv
`timescale 1ns/1ps
module baud_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] staged_div,
  input  logic             staged_slow,
  input  logic             pre_en,
  output logic             active,
  output logic             act_slow,
  output logic             tick16
);
  logic [DIV_W-1:0] cur_div;
  logic [DIV_W-1:0] dcnt;
  logic             terminal;

  assign active   = (cur_div != '0);
  assign terminal = (dcnt == cur_div - 1'b1);
  assign tick16   = active && pre_en && terminal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_div  <= '0;
      act_slow <= 1'b0;
      dcnt     <= '0;
    end else if (!active || tick16) begin
      cur_div  <= staged_div;
      act_slow <= staged_slow;
      dcnt     <= '0;
    end else if (pre_en) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // R5: settings in use never change partway through a period
  a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick16) |=> ($stable(cur_div) && $stable(act_slow)));

  // R4: each tick restarts the count
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |=> (dcnt == '0));

  // R4: count stays inside the active divisor
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (dcnt < cur_div));
endmodule

// File: rtl/baud_bitcnt.sv
`timescale 1ns/1ps
module baud_bitcnt #(
  parameter int unsigned OVERSAMPLE = 16,
  localparam int unsigned SUB_W     = $clog2(OVERSAMPLE)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  output logic tick1
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [SUB_W-1:0] sub;

  assign tick1 = tick16 && (sub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      sub <= '0;
    else if (tick1)  sub <= '0;
    else if (tick16) sub <= sub + 1'b1;
  end

  // R7: the sub-count starts over after each bit tick
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |=> (sub == '0));

  // R7: sub-count only moves on a 16x tick
  a_r7_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(sub));
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SEL_BIT    = 7,
  parameter int unsigned PRE_SLOW   = 4,
  parameter int unsigned OVERSAMPLE = 16,
  localparam int unsigned DIV_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick16,
  output logic              tick1
);
  logic [DIV_W-1:0] staged_div;
  logic             staged_slow;
  logic             active;
  logic             act_slow;
  logic             pre_en;

  baud_regs #(.BYTE_W(BYTE_W), .SEL_BIT(SEL_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .staged_div(staged_div), .staged_slow(staged_slow)
  );

  baud_prescaler #(.PRE_SLOW(PRE_SLOW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(tick16), .slow(act_slow),
    .pre_en(pre_en)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .staged_div(staged_div), .staged_slow(staged_slow),
    .pre_en(pre_en), .active(active), .act_slow(act_slow), .tick16(tick16)
  );

  baud_bitcnt #(.OVERSAMPLE(OVERSAMPLE)) u_bit (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tick1(tick1)
  );

  // R1: nothing ticks while no divisor is in use
  a_r1_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!tick16 && !tick1));

  // R6: a parked generator only wakes from a nonzero committed divisor
  a_r6_stay_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && staged_div == '0) |=> !active);
endmodule

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick16, tick1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cyc = 0, last_t = -1, last_iv = 0, tick_cnt = 0;
  int s16 = 0, b_iv = 0, b_cnt = 0;

  always #5 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick16(tick16), .tick1(tick1)
  );

  // Interval monitor, sampling away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tick16) begin
      if (last_t >= 0) last_iv = cyc - last_t;
      last_t = cyc;
      s16 = s16 + 1;
      if (tick1) begin
        b_iv = s16;
        s16 = 0;
        b_cnt = b_cnt + 1;
      end
      tick_cnt = tick_cnt + 1;
    end
  end

  function automatic int exp_period(input int d, input bit slow);
    int r;
    r = slow ? 4 : 1;
    return r * d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(2'd0, 8'(d & 255));
    wr(2'd1, 8'((d >> 8) & 255));
  endtask

  task automatic wait_tick();
    int k;
    k = tick_cnt;
    wait (tick_cnt != k);
  endtask

  task automatic expect_iv(input int exp, input string req);
    wait_tick();
    check(last_iv == exp, req, last_iv, exp);
  endtask

  task automatic no_ticks(input int n, input string req);
    int k;
    k = tick_cnt;
    repeat (n) @(negedge clk);
    check(tick_cnt == k, req, tick_cnt - k, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet after reset
    check(!tick16 && !tick1, "R1 reset outputs", int'(tick16) + int'(tick1), 0);
    no_ticks(50, "R1 no tick before divisor");

    // R2: low byte alone does not start the generator
    wr(2'd0, 8'd5);
    no_ticks(50, "R2 low byte held");

    // R4: divisor 5, divide-by-1
    wr(2'd1, 8'd0);
    wait_tick();
    for (int i = 0; i < 3; i++) expect_iv(exp_period(5, 1'b0), "R4 interval d5 p1");

    // R7: 16 tick16 between bit ticks
    begin
      int k;
      k = b_cnt;
      wait (b_cnt == k + 1);
      wait (b_cnt == k + 2);
      check(b_iv == 16, "R7 bit tick spacing", b_iv, 16);
    end

    // R5: change divisor right after a tick; old period completes
    wait_tick();
    set_div(9);
    expect_iv(5, "R5 old divisor kept");
    expect_iv(9, "R5 new divisor applied");

    // R3: divide-by-4 from bit 7, effective at next tick
    wait_tick();
    wr(2'd2, 8'h80);
    expect_iv(9, "R3 R5 prescale change deferred");
    expect_iv(exp_period(9, 1'b1), "R3 divide-by-4");

    // R3: other control bits ignored, bit 7 clear gives divide-by-1
    wait_tick();
    wr(2'd2, 8'h7F);
    wait_tick();
    expect_iv(9, "R3 bit7 clear divide-by-1");

    // R8: unused address, R2: low-only write while running
    wait_tick();
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'd2);
    wait_tick();
    expect_iv(9, "R8 R2 stray writes inert");

    // R9: fastest setting
    set_div(1);
    wait_tick();
    wait_tick();
    for (int i = 0; i < 4; i++) expect_iv(1, "R9 every cycle");

    // R4: both bytes in use, divide-by-4
    wr(2'd2, 8'h80);
    set_div(16'h0102);
    wait_tick();
    expect_iv(exp_period(16'h0102, 1'b1), "R4 two-byte divisor p4");

    // R4: seeded random settings
    for (int i = 0; i < 8; i++) begin
      int d;
      bit s;
      d = 1 + int'($urandom_range(39));
      s = bit'($urandom_range(1));
      wr(2'd2, {s, 7'd0});
      set_div(d);
      wait_tick();
      expect_iv(exp_period(d, s), "R4 random interval");
    end

    // R6: zero divisor parks after the current period
    set_div(0);
    wait_tick();
    no_ticks(2000, "R6 parked after zero");

    done = 1'b1;
    finish_run();
  end
endmodule